// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Preamble

This block serialises characters onto an asynchronous serial line. Characters arrive on a valid/ready input. Each character carries two flags. One marks the first character of a buffer. The other asks for a preamble before that buffer. When both flags are set on an accepted character, the block first holds the line at mark (logic one) for one full character time. The length of that idle run is taken from the configured frame format. The character follows the idle run.

Buffers without a preamble request are sent back to back with no idle gap. The start bit of a waiting character follows the last stop bit directly. A character that has been accepted is always sent in full. A baud tick input paces the bit timing, and each bit lasts a fixed number of ticks. Baud generation and buffer management are done outside this block.

Top module: `uart_tx_pre`

## Requirements
- R1: After reset, and whenever no character is in flight, txd_o is 1, busy_o is 0 and ready_o is 1.
- R2: A frame is sent in this order: a start bit of 0, then the data bits with the LSB first, then the parity bit if one is configured, then STOP_W stop bits of 1. Each bit lasts TICKS_PER_BIT cycles in which baud_tick_i is high. The start bit appears on the clock edge that accepts the character.
- R3: With even parity, the parity bit makes the count of ones across data and parity even. With odd parity, that count is odd. With no parity, the stop bits follow the data directly.
- R4: A character accepted with sob_i=1 and pre_i=1 is preceded by 1+DATA_W+P+STOP_W one-bits, where P is 1 with parity and 0 without. For 8 data bits, no parity and 1 stop bit this is 10 one-bits. The start bit follows the last preamble bit directly.
- R5: pre_i has no effect on a character accepted with sob_i=0. No preamble is sent for it.
- R6: ready_o is high only when the block is idle, or in the cycle that ends the last stop bit of a frame. When a character is waiting at that point, its start bit follows the stop bit with no gap.
- R7: While baud_tick_i is low, txd_o holds its value and the current bit does not advance.
- R8: After a character is accepted, later changes on data_i, sob_i, pre_i or valid_i do not change the frame being sent.
- R9: busy_o is high from the cycle after acceptance until the last stop bit ends with no further character accepted. busy_o is high during a preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Baud tick; one pulse per bit sub-period |
| valid_i | input | 1 | A character is offered |
| data_i | input | DATA_W | Character to send |
| sob_i | input | 1 | Character is the first of a buffer |
| pre_i | input | 1 | Buffer requests an idle preamble |
| ready_o | output | 1 | Character is taken on this edge if valid_i is high |
| txd_o | output | 1 | Serial line, idles at 1 |
| busy_o | output | 1 | A frame or preamble is in progress |

## Verification
The line output is registered, so bit k of a frame is visible from cycle k*TICKS_PER_BIT after the accepting edge. With a preamble, every bit moves later by one full frame length. The bench builds the expected bit stream from the requirements for each of three frame formats. From the first falling edge after busy_o rises, it compares txd_o with that stream at every falling edge, so each sample lands mid-cycle within a known bit. When the stream ends, the bench expects the idle state in the very next cycle. In the tick-hold test the ticks are gated off after acceptance, and counting restarts from the falling edge where they resume.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD} parity_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_FRAME} tx_state_e;

  function automatic int frame_bits(input int dw, input parity_e par, input int sw);
    return 1 + dw + ((par == PAR_NONE) ? 0 : 1) + sw;
  endfunction
endpackage

// File: rtl/uart_frame_build.sv
module uart_frame_build #(
  parameter int DATA_W = 8,
  parameter uart_tx_pkg::parity_e PARITY = uart_tx_pkg::PAR_NONE,
  parameter int STOP_W = 1,
  localparam int FRAME_W = uart_tx_pkg::frame_bits(DATA_W, PARITY, STOP_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o
);
  // bit 0 leaves the line first
  generate
    if (PARITY == uart_tx_pkg::PAR_NONE) begin : g_nopar
      assign frame_o = {{STOP_W{1'b1}}, data_i, 1'b0};
    end else begin : g_par
      logic par_bit;
      assign par_bit = (^data_i) ^ (PARITY == uart_tx_pkg::PAR_ODD);
      assign frame_o = {{STOP_W{1'b1}}, par_bit, data_i, 1'b0};
    end
  endgenerate
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
  parameter int TICKS = 16,
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bit_end_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  p_cnt_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_no_tick_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !restart_i |=> $stable(cnt_q));
endmodule

// File: rtl/uart_tx_pre.sv
module uart_tx_pre #(
  parameter int DATA_W = 8,
  parameter uart_tx_pkg::parity_e PARITY = uart_tx_pkg::PAR_NONE,
  parameter int STOP_W = 1,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sob_i,
  input  logic              pre_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              busy_o
);
  import uart_tx_pkg::*;

  localparam int FRAME_W = frame_bits(DATA_W, PARITY, STOP_W);
  localparam int BC_W = $clog2(FRAME_W);
  localparam logic [BC_W-1:0] BC_TOP = BC_W'(FRAME_W - 1);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] shreg_q, hold_q, frame_in;
  logic [BC_W-1:0]    bit_cnt_q;
  logic               bit_end, last_bit, accept, want_pre;

  uart_frame_build #(.DATA_W(DATA_W), .PARITY(PARITY), .STOP_W(STOP_W)) i_build (
    .data_i (data_i),
    .frame_o(frame_in)
  );

  uart_bit_timer #(.TICKS(TICKS_PER_BIT)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(accept),
    .run_i    (busy_o),
    .tick_i   (baud_tick_i),
    .bit_end_o(bit_end)
  );

  assign busy_o   = (state_q != ST_IDLE);
  assign last_bit = (bit_cnt_q == '0);
  assign ready_o  = (state_q == ST_IDLE) || (state_q == ST_FRAME && last_bit && bit_end);
  assign accept   = valid_i && ready_o;
  assign want_pre = sob_i && pre_i;
  assign txd_o    = shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '1;
      hold_q    <= '1;
      bit_cnt_q <= '0;
    end else if (accept) begin
      bit_cnt_q <= BC_TOP;
      if (want_pre) begin
        state_q <= ST_PRE;
        shreg_q <= '1;
        hold_q  <= frame_in;
      end else begin
        state_q <= ST_FRAME;
        shreg_q <= frame_in;
      end
    end else if (bit_end) begin
      if (!last_bit) begin
        shreg_q   <= {1'b1, shreg_q[FRAME_W-1:1]};
        bit_cnt_q <= bit_cnt_q - 1'b1;
      end else if (state_q == ST_PRE) begin
        state_q   <= ST_FRAME;
        shreg_q   <= hold_q;
        bit_cnt_q <= BC_TOP;
      end else begin
        state_q <= ST_IDLE;
        shreg_q <= '1;
      end
    end
  end

  p_idle_mark_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o && ready_o);
  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !want_pre |=> !txd_o);
  p_pre_mark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PRE |-> txd_o);
  p_pre_enter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && want_pre |=> state_q == ST_PRE);
  p_no_pre_mid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !sob_i |=> state_q == ST_FRAME);
  p_hold_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !baud_tick_i |=> $stable(txd_o));
  p_busy_after_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
endmodule

// File: tb/test_uart_tx_pre.sv
`timescale 1ns/1ps
module test_uart_tx_pre;
  import uart_tx_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic valid = 1'b0;
  logic sob = 1'b0;
  logic pre = 1'b0;
  logic [7:0] din = '0;
  int sel = 0;
  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] it_d [4];
  logic       it_s [4];
  logic       it_p [4];
  bit exp_q [$];

  logic rdy0, txd0, bsy0, rdy1, txd1, bsy1, rdy2, txd2, bsy2;
  logic ready_m, txd_m, busy_m;

  always #5 clk = ~clk;

  uart_tx_pre #(.TICKS_PER_BIT(4)) i_uart_tx_pre (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .valid_i(valid && sel == 0),
    .data_i(din), .sob_i(sob), .pre_i(pre), .ready_o(rdy0), .txd_o(txd0), .busy_o(bsy0));

  uart_tx_pre #(.DATA_W(7), .PARITY(PAR_ODD), .STOP_W(2), .TICKS_PER_BIT(2)) i_uart_tx_pre_odd (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .valid_i(valid && sel == 1),
    .data_i(din[6:0]), .sob_i(sob), .pre_i(pre), .ready_o(rdy1), .txd_o(txd1), .busy_o(bsy1));

  uart_tx_pre #(.PARITY(PAR_EVEN), .TICKS_PER_BIT(3)) i_uart_tx_pre_even (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .valid_i(valid && sel == 2),
    .data_i(din), .sob_i(sob), .pre_i(pre), .ready_o(rdy2), .txd_o(txd2), .busy_o(bsy2));

  always_comb begin
    case (sel)
      1:       begin ready_m = rdy1; txd_m = txd1; busy_m = bsy1; end
      2:       begin ready_m = rdy2; txd_m = txd2; busy_m = bsy2; end
      default: begin ready_m = rdy0; txd_m = txd0; busy_m = bsy0; end
    endcase
  end

  function automatic int cfg_dw(input int s);  return (s == 1) ? 7 : 8; endfunction
  function automatic int cfg_par(input int s); return (s == 1) ? 2 : (s == 2) ? 1 : 0; endfunction
  function automatic int cfg_sw(input int s);  return (s == 1) ? 2 : 1; endfunction
  function automatic int cfg_t(input int s);   return (s == 1) ? 2 : (s == 2) ? 3 : 4; endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_pre(input int s);
    for (int i = 0; i < 1 + cfg_dw(s) + (cfg_par(s) != 0 ? 1 : 0) + cfg_sw(s); i++) exp_q.push_back(1'b1);
  endtask

  task automatic add_frame(input int s, input logic [7:0] d);
    bit p;
    p = 1'b0;
    exp_q.push_back(1'b0);
    for (int i = 0; i < cfg_dw(s); i++) begin
      exp_q.push_back(d[i]);
      p = p ^ d[i];
    end
    if (cfg_par(s) == 1) exp_q.push_back(p);
    if (cfg_par(s) == 2) exp_q.push_back(~p);
    for (int i = 0; i < cfg_sw(s); i++) exp_q.push_back(1'b1);
  endtask

  // compares from the current falling edge, one bit per cfg_t cycles
  task automatic check_bits(input string req);
    bit ok;
    logic a;
    for (int i = 0; i < exp_q.size(); i++) begin
      ok = 1'b1;
      a = exp_q[i];
      for (int c = 0; c < cfg_t(sel); c++) begin
        if (txd_m !== exp_q[i] || busy_m !== 1'b1) begin
          ok = 1'b0;
          a = txd_m;
        end
        @(negedge clk);
      end
      chk(ok, req, $sformatf("bit %0d txd", i), int'(a), int'(exp_q[i]));
    end
    chk(txd_m === 1'b1 && busy_m === 1'b0, "R9", "idle after stream busy", int'(busy_m), 0);
  endtask

  task automatic run_stream(input int s, input int n, input string req);
    sel = s;
    exp_q.delete();
    for (int k = 0; k < n; k++) begin
      if (it_s[k] && it_p[k]) add_pre(s);
      add_frame(s, it_d[k]);
    end
    fork
      begin
        for (int k = 0; k < n; k++) begin
          din = it_d[k]; sob = it_s[k]; pre = it_p[k]; valid = 1'b1;
          while (!ready_m) @(negedge clk);
          @(negedge clk);
        end
        valid = 1'b0; din = ~din; sob = 1'b1; pre = 1'b1;  // R8: late input changes
      end
      begin
        while (!busy_m) @(negedge clk);
        check_bits(req);
      end
    join
    sob = 1'b0; pre = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(txd0 === 1'b1, "R1", "reset txd", int'(txd0), 1);
    chk(rdy0 === 1'b1, "R1", "reset ready", int'(rdy0), 1);
    chk(bsy0 === 1'b0, "R1", "reset busy", int'(bsy0), 0);
  endtask

  task automatic t_single;
    it_d[0] = 8'hA6; it_s[0] = 1'b1; it_p[0] = 1'b0;
    run_stream(0, 1, "R2/R8");
  endtask

  task automatic t_preamble;
    it_d[0] = 8'h3C; it_s[0] = 1'b1; it_p[0] = 1'b1;
    run_stream(0, 1, "R4");
  endtask

  task automatic t_pre_first_only;
    it_d[0] = 8'h81; it_s[0] = 1'b1; it_p[0] = 1'b1;
    it_d[1] = 8'h5A; it_s[1] = 1'b0; it_p[1] = 1'b1;
    run_stream(0, 2, "R5");
  endtask

  task automatic t_back_to_back;
    it_d[0] = 8'h01; it_s[0] = 1'b1; it_p[0] = 1'b0;
    it_d[1] = 8'hFE; it_s[1] = 1'b1; it_p[1] = 1'b0;
    it_d[2] = 8'h00; it_s[2] = 1'b0; it_p[2] = 1'b0;
    run_stream(0, 3, "R6");
  endtask

  task automatic t_parity_odd;
    it_d[0] = 8'h55; it_s[0] = 1'b1; it_p[0] = 1'b1;
    it_d[1] = 8'h07; it_s[1] = 1'b0; it_p[1] = 1'b0;
    run_stream(1, 2, "R3/R4");
  endtask

  task automatic t_parity_even;
    it_d[0] = 8'h81; it_s[0] = 1'b1; it_p[0] = 1'b0;
    it_d[1] = 8'h07; it_s[1] = 1'b0; it_p[1] = 1'b0;
    run_stream(2, 2, "R3");
  endtask

  task automatic t_tick_hold;
    bit ok_line, ok_rdy;
    sel = 0;
    exp_q.delete();
    add_frame(0, 8'hC3);
    tick = 1'b0;
    din = 8'hC3; sob = 1'b1; pre = 1'b0; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; din = 8'h00;
    ok_line = 1'b1; ok_rdy = 1'b1;
    for (int c = 0; c < 12; c++) begin
      if (txd_m !== 1'b0 || busy_m !== 1'b1) ok_line = 1'b0;
      if (ready_m !== 1'b0) ok_rdy = 1'b0;
      @(negedge clk);
    end
    chk(ok_line, "R7", "line held without ticks", int'(txd_m), 0);
    chk(ok_rdy, "R6", "ready low mid frame", int'(ready_m), 0);
    tick = 1'b1;
    check_bits("R7");
    sob = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_preamble();
    t_pre_first_only();
    t_back_to_back();
    t_tick_hold();
    t_parity_odd();
    t_parity_even();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule